// File: doc/BRIEF.md
# PHY Discovery and Duplex Sequencer

This block is a control state machine for an Ethernet MAC that drives a register-level request/response port of a serial management master. On a scan request it probes every PHY address. It reads the basic status register at each one and accepts a transceiver when the status bits show a plausible PHY. For each PHY it finds, it repairs an empty advertisement register from the PHY's own capability bits and brings the control register into line with the configured media mode. It keeps the addresses of the PHYs it finds in a small table.

On a check request it examines the first PHY in the table. It reads the status register, and reads it once more if the latched-low link bit is clear. If the link is up, it reads the link-partner ability register and masks it with the value that was advertised. From that result it resolves the duplex mode and the transmit-threshold setting for the MAC. Whenever either setting changes, it applies the new value and pulses a receive/transmit restart request.

Only read and write requests leave the block. Bit-level serial signalling belongs to the master behind the port.

Top module: `phy_mgmt_seq`

## Requirements
- R1: A scan probes addresses 1, 2, …, 31 and then 0, in that order, with one read of register 1 (status) per address. Accepted addresses fill `phy_addrs` from entry 0 upward, with entry i at bits [5i+4:5i].
- R2: An address is accepted when (status & 0x8301) == 0x8001, or when status bit 15 is 0 and status bits 14:11 are not all zero. Otherwise it is skipped and none of its other registers is read or written.
- R3: The scan stops once `phy_count` reaches MAX_PHYS. No address after that point is read, and `phy_count` never exceeds MAX_PHYS.
- R4: If register 4 (advertisement) of an accepted PHY has bits 8:5 all zero, the value ((status >> 6) & 0x03E0) | 1 is written to register 4 and used as that PHY's advertised value. Otherwise register 4 is not written.
- R5: In negotiation mode (`cfg_autoneg`=1), the new control value is register 0 with bit 12 set. If that changes the register, bit 9 is also set.
- R6: In forced mode (`cfg_autoneg`=0), register 0 bits 14, 13, 12, 11, 10, 8 and 7 are cleared. Then bit 8 is set if `cfg_force_fd` is 1 and bit 13 is set if `cfg_force_100` is 1.
- R7: Register 0 is written only when the new control value differs from the value read. The block only ever writes registers 0 and 4.
- R8: A check reads register 1 of the first table entry. If bit 2 (link) is 0, register 1 is read a second time. Only a second 0 sets `link_up` to 0, and in that case `full_duplex` and `tx_threshold` are left unchanged.
- R9: With the link up, the negotiated set is register 5 ANDed with the advertised value of entry 0. Duplex is resolved by priority: bit 8 (100 full) gives full, else bit 7 (100 half) gives half, else bit 6 (10 full) gives full, else half. `cfg_fd_lock`=1 forces full.
- R10: `tx_threshold` is 0 when the negotiated set has bit 8 or bit 7 set, and 1 otherwise.
- R11: `rxtx_restart` pulses for one cycle, in the same cycle the new values appear, exactly when `full_duplex` or `tx_threshold` changes.
- R12: Once `mreq_valid` is raised, it and the request fields stay stable until a cycle in which `mrsp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_start | input | 1 | Pulse: start a PHY scan (accepted only while idle) |
| check_start | input | 1 | Pulse: start a link/duplex check (accepted only while idle) |
| cfg_autoneg | input | 1 | 1 = negotiation mode, 0 = forced media |
| cfg_force_fd | input | 1 | Forced full duplex in forced mode |
| cfg_force_100 | input | 1 | Forced 100 Mb/s in forced mode |
| cfg_fd_lock | input | 1 | Override the resolved duplex to full |
| mreq_valid | output | 1 | Management request pending |
| mreq_write | output | 1 | 1 = write, 0 = read |
| mreq_phy | output | 5 | Target PHY address |
| mreq_reg | output | 5 | Target register number |
| mreq_wdata | output | 16 | Write data |
| mrsp_valid | input | 1 | Response for the pending request |
| mrsp_rdata | input | 16 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a scan or check ends |
| phy_count | output | $clog2(MAX_PHYS+1) | Number of PHYs found |
| phy_addrs | output | 5*MAX_PHYS | Found addresses, entry i at [5i+4:5i] |
| link_up | output | 1 | Result of the last check |
| full_duplex | output | 1 | Duplex setting for the MAC |
| tx_threshold | output | 1 | Transmit-threshold setting for the MAC |
| rxtx_restart | output | 1 | One-cycle restart request |

## Verification
The bound checker checks four things on every cycle: that request fields hold still while a request waits, that the table count stays within its depth, that only the control and advertisement registers are ever written, and that a restart pulse comes with a duplex or threshold change and never without one. The bench scenarios cover what the checker cannot see cycle by cycle. These are the probe order and the acceptance rule across a full address sweep, the early stop once the table is full, the advertisement and control values that reach the PHY model, the second status read after a single latched-low link report, and the duplex and threshold priority over a table of partner abilities.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam logic [4:0] REG_CTRL = 5'd0;
    localparam logic [4:0] REG_STAT = 5'd1;
    localparam logic [4:0] REG_ADV  = 5'd4;
    localparam logic [4:0] REG_LPA  = 5'd5;

    localparam logic [15:0] ABIL_MASK   = 16'h01E0;
    localparam logic [15:0] CTRL_AN_EN  = 16'h1000;
    localparam logic [15:0] CTRL_AN_RST = 16'h0200;
    localparam logic [15:0] CTRL_FDX    = 16'h0100;
    localparam logic [15:0] CTRL_SPD100 = 16'h2000;
    localparam logic [15:0] CTRL_FORCE_CLR = 16'h7D80;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCAN_STAT,
        ST_SCAN_CTRL,
        ST_SCAN_ADV,
        ST_SCAN_WADV,
        ST_SCAN_WCTRL,
        ST_CHK_STAT1,
        ST_CHK_STAT2,
        ST_CHK_LPA
    } seq_st_e;

    typedef struct packed {
        logic        v;
        logic        w;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] wd;
    } mreq_t;

    function automatic mreq_t mk_req(input logic w, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] wd);
        mreq_t r;
        r.v = 1'b1;
        r.w = w;
        r.phy = phy;
        r.rg = rg;
        r.wd = wd;
        return r;
    endfunction

endpackage

// File: rtl/phy_presence.sv
module phy_presence (
    input  logic [15:0] stat,
    output logic        present
);
    always_comb begin
        present = ((stat & 16'h8301) == 16'h8001) ||
                  (!stat[15] && (stat[14:11] != 4'd0));
    end
endmodule

// File: rtl/phy_ctrl_fixup.sv
module phy_ctrl_fixup
    import phy_seq_pkg::*;
(
    input  logic [15:0] stat,
    input  logic [15:0] adv_rd,
    input  logic [15:0] ctrl,
    input  logic        autoneg,
    input  logic        force_fd,
    input  logic        force_100,
    output logic        adv_fix,
    output logic [15:0] adv_eff,
    output logic [15:0] ctrl_new
);
    logic [15:0] an_val;

    always_comb begin
        adv_fix = (adv_rd & ABIL_MASK) == 16'h0000;
        adv_eff = adv_fix ? (((stat >> 6) & 16'h03E0) | 16'h0001) : adv_rd;

        an_val = ctrl | CTRL_AN_EN;
        if (autoneg) begin
            ctrl_new = (an_val != ctrl) ? (an_val | CTRL_AN_RST) : an_val;
        end else begin
            ctrl_new = ctrl & ~CTRL_FORCE_CLR;
            if (force_fd)  ctrl_new = ctrl_new | CTRL_FDX;
            if (force_100) ctrl_new = ctrl_new | CTRL_SPD100;
        end
    end
endmodule

// File: rtl/phy_duplex_resolve.sv
module phy_duplex_resolve (
    input  logic [15:0] lpa,
    input  logic [15:0] adv,
    input  logic        fd_lock,
    output logic        fd,
    output logic        thr
);
    logic [15:0] neg;

    always_comb begin
        neg = lpa & adv;
        if (neg[8])      fd = 1'b1;
        else if (neg[7]) fd = 1'b0;
        else if (neg[6]) fd = 1'b1;
        else             fd = 1'b0;
        if (fd_lock) fd = 1'b1;
        thr = !(neg[8] || neg[7]);
    end
endmodule

// File: rtl/phy_mgmt_seq.sv
module phy_mgmt_seq
    import phy_seq_pkg::*;
#(
    parameter int MAX_PHYS = 4,
    localparam int CW = $clog2(MAX_PHYS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_start,
    input  logic                  check_start,
    input  logic                  cfg_autoneg,
    input  logic                  cfg_force_fd,
    input  logic                  cfg_force_100,
    input  logic                  cfg_fd_lock,
    output logic                  mreq_valid,
    output logic                  mreq_write,
    output logic [4:0]            mreq_phy,
    output logic [4:0]            mreq_reg,
    output logic [15:0]           mreq_wdata,
    input  logic                  mrsp_valid,
    input  logic [15:0]           mrsp_rdata,
    output logic                  busy,
    output logic                  done,
    output logic [CW-1:0]         phy_count,
    output logic [5*MAX_PHYS-1:0] phy_addrs,
    output logic                  link_up,
    output logic                  full_duplex,
    output logic                  tx_threshold,
    output logic                  rxtx_restart
);

    typedef struct packed {
        seq_st_e                      st;
        logic [5:0]                   iter;
        logic [CW-1:0]                count;
        logic [MAX_PHYS-1:0][4:0]     addrs;
        logic [15:0]                  stat;
        logic [15:0]                  ctrl;
        logic [15:0]                  adv_cur;
        logic [15:0]                  adv0;
        mreq_t                        req;
        logic                         link;
        logic                         fd;
        logic                         thr;
        logic                         restart;
        logic                         done;
    } seq_state_t;

    seq_state_t q, d;

    logic        present;
    logic        adv_fix;
    logic [15:0] adv_eff;
    logic [15:0] ctrl_new;
    logic        res_fd;
    logic        res_thr;
    logic [4:0]  cur_phy;

    assign cur_phy = q.iter[4:0];

    phy_presence u_presence (
        .stat    (mrsp_rdata),
        .present (present)
    );

    phy_ctrl_fixup u_fixup (
        .stat      (q.stat),
        .adv_rd    (mrsp_rdata),
        .ctrl      (q.ctrl),
        .autoneg   (cfg_autoneg),
        .force_fd  (cfg_force_fd),
        .force_100 (cfg_force_100),
        .adv_fix   (adv_fix),
        .adv_eff   (adv_eff),
        .ctrl_new  (ctrl_new)
    );

    phy_duplex_resolve u_resolve (
        .lpa     (mrsp_rdata),
        .adv     (q.adv0),
        .fd_lock (cfg_fd_lock),
        .fd      (res_fd),
        .thr     (res_thr)
    );

    logic        do_ctrl;
    logic        do_record;
    logic        step_addr;
    logic [15:0] rec_adv;

    always_comb begin
        d = q;
        d.restart = 1'b0;
        d.done = 1'b0;
        do_ctrl = 1'b0;
        do_record = 1'b0;
        step_addr = 1'b0;
        rec_adv = q.adv_cur;
        if (q.req.v && mrsp_valid) d.req.v = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (scan_start) begin
                    d.count = '0;
                    d.iter = 6'd1;
                    d.req = mk_req(1'b0, 5'd1, REG_STAT, 16'h0);
                    d.st = ST_SCAN_STAT;
                end else if (check_start) begin
                    if (q.count == '0) begin
                        d.link = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.req = mk_req(1'b0, q.addrs[0], REG_STAT, 16'h0);
                        d.st = ST_CHK_STAT1;
                    end
                end
            end
            ST_SCAN_STAT: if (mrsp_valid) begin
                if (present) begin
                    d.stat = mrsp_rdata;
                    d.req = mk_req(1'b0, cur_phy, REG_CTRL, 16'h0);
                    d.st = ST_SCAN_CTRL;
                end else begin
                    step_addr = 1'b1;
                end
            end
            ST_SCAN_CTRL: if (mrsp_valid) begin
                d.ctrl = mrsp_rdata;
                d.req = mk_req(1'b0, cur_phy, REG_ADV, 16'h0);
                d.st = ST_SCAN_ADV;
            end
            ST_SCAN_ADV: if (mrsp_valid) begin
                d.adv_cur = adv_eff;
                rec_adv = adv_eff;
                if (adv_fix) begin
                    d.req = mk_req(1'b1, cur_phy, REG_ADV, adv_eff);
                    d.st = ST_SCAN_WADV;
                end else begin
                    do_ctrl = 1'b1;
                end
            end
            ST_SCAN_WADV:  if (mrsp_valid) do_ctrl = 1'b1;
            ST_SCAN_WCTRL: if (mrsp_valid) do_record = 1'b1;
            ST_CHK_STAT1, ST_CHK_STAT2: if (mrsp_valid) begin
                if (mrsp_rdata[2]) begin
                    d.req = mk_req(1'b0, q.addrs[0], REG_LPA, 16'h0);
                    d.st = ST_CHK_LPA;
                end else if (q.st == ST_CHK_STAT1) begin
                    d.req = mk_req(1'b0, q.addrs[0], REG_STAT, 16'h0);
                    d.st = ST_CHK_STAT2;
                end else begin
                    d.link = 1'b0;
                    d.done = 1'b1;
                    d.st = ST_IDLE;
                end
            end
            ST_CHK_LPA: if (mrsp_valid) begin
                d.link = 1'b1;
                if (res_fd != q.fd || res_thr != q.thr) begin
                    d.fd = res_fd;
                    d.thr = res_thr;
                    d.restart = 1'b1;
                end
                d.done = 1'b1;
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (do_ctrl) begin
            if (ctrl_new != q.ctrl) begin
                d.req = mk_req(1'b1, cur_phy, REG_CTRL, ctrl_new);
                d.st = ST_SCAN_WCTRL;
            end else begin
                do_record = 1'b1;
            end
        end

        if (do_record) begin
            for (int i = 0; i < MAX_PHYS; i++) begin
                if (q.count == CW'(i)) d.addrs[i] = cur_phy;
            end
            if (q.count == '0) d.adv0 = rec_adv;
            d.count = q.count + 1'b1;
            step_addr = 1'b1;
        end

        if (step_addr) begin
            if (d.count == CW'(MAX_PHYS) || q.iter == 6'd32) begin
                d.st = ST_IDLE;
                d.done = 1'b1;
            end else begin
                d.iter = q.iter + 6'd1;
                d.req = mk_req(1'b0, d.iter[4:0], REG_STAT, 16'h0);
                d.st = ST_SCAN_STAT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mreq_valid   = q.req.v;
    assign mreq_write   = q.req.w;
    assign mreq_phy     = q.req.phy;
    assign mreq_reg     = q.req.rg;
    assign mreq_wdata   = q.req.wd;
    assign busy         = (q.st != ST_IDLE);
    assign done         = q.done;
    assign phy_count    = q.count;
    assign phy_addrs    = q.addrs;
    assign link_up      = q.link;
    assign full_duplex  = q.fd;
    assign tx_threshold = q.thr;
    assign rxtx_restart = q.restart;

endmodule

// File: rtl/phy_mgmt_seq_chk.sv
module phy_mgmt_seq_chk #(
    parameter int MAX_PHYS = 4,
    localparam int CW = $clog2(MAX_PHYS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mreq_valid,
    input logic          mreq_write,
    input logic [4:0]    mreq_phy,
    input logic [4:0]    mreq_reg,
    input logic [15:0]   mreq_wdata,
    input logic          mrsp_valid,
    input logic [CW-1:0] phy_count,
    input logic          full_duplex,
    input logic          tx_threshold,
    input logic          rxtx_restart
);

    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mrsp_valid) |=> (mreq_valid && $stable(mreq_write) &&
            $stable(mreq_phy) && $stable(mreq_reg) && $stable(mreq_wdata)));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        phy_count <= CW'(MAX_PHYS));

    a_r7_write_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && mreq_write) |-> (mreq_reg == 5'd0 || mreq_reg == 5'd4));

    a_r11_restart_has_change: assert property (@(posedge clk) disable iff (!rst_n)
        rxtx_restart |-> (full_duplex != $past(full_duplex) ||
                          tx_threshold != $past(tx_threshold)));

    a_r11_change_has_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex != $past(full_duplex) || tx_threshold != $past(tx_threshold))
            |-> rxtx_restart);

endmodule

bind phy_mgmt_seq phy_mgmt_seq_chk #(.MAX_PHYS(MAX_PHYS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mreq_valid   (mreq_valid),
    .mreq_write   (mreq_write),
    .mreq_phy     (mreq_phy),
    .mreq_reg     (mreq_reg),
    .mreq_wdata   (mreq_wdata),
    .mrsp_valid   (mrsp_valid),
    .phy_count    (phy_count),
    .full_duplex  (full_duplex),
    .tx_threshold (tx_threshold),
    .rxtx_restart (rxtx_restart)
);

// File: tb/phy_mgmt_seq_tb.sv
module phy_mgmt_seq_tb;

    localparam int MAX_PHYS = 4;
    localparam int CW = $clog2(MAX_PHYS + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_start = 1'b0, check_start = 1'b0;
    logic cfg_autoneg = 1'b1, cfg_force_fd = 1'b0, cfg_force_100 = 1'b0, cfg_fd_lock = 1'b0;
    logic mreq_valid, mreq_write;
    logic [4:0] mreq_phy, mreq_reg;
    logic [15:0] mreq_wdata;
    logic mrsp_valid;
    logic [15:0] mrsp_rdata;
    logic busy, done, link_up, full_duplex, tx_threshold, rxtx_restart;
    logic [CW-1:0] phy_count;
    logic [5*MAX_PHYS-1:0] phy_addrs;

    always #5 clk = ~clk;

    phy_mgmt_seq #(.MAX_PHYS(MAX_PHYS)) u_dut (.*);

    // PHY register model: initial values from the stimulus, DUT writes kept apart
    logic [15:0] init_reg [0:31][0:7];
    logic [15:0] wr_val   [0:31][0:7];
    logic        wr_seen  [0:31][0:7];
    int          wr_cnt   [0:31];
    int          stat_rd_cnt;
    int          drop_until = 0;
    logic        clr_model = 1'b0;

    always @(posedge clk) begin
        if (!rst_n || clr_model) begin
            mrsp_valid <= 1'b0;
            mrsp_rdata <= 16'h0;
            for (int p = 0; p < 32; p++) begin
                wr_cnt[p] <= 0;
                for (int r = 0; r < 8; r++) wr_seen[p][r] <= 1'b0;
            end
            if (!rst_n) stat_rd_cnt <= 0;
        end else if (mreq_valid && !mrsp_valid) begin
            mrsp_valid <= 1'b1;
            if (mreq_write) begin
                wr_val[mreq_phy][mreq_reg[2:0]]  <= mreq_wdata;
                wr_seen[mreq_phy][mreq_reg[2:0]] <= 1'b1;
                wr_cnt[mreq_phy] <= wr_cnt[mreq_phy] + 1;
            end else begin
                mrsp_rdata <= wr_seen[mreq_phy][mreq_reg[2:0]] ? wr_val[mreq_phy][mreq_reg[2:0]]
                                                               : init_reg[mreq_phy][mreq_reg[2:0]];
                if (mreq_reg == 5'd1) begin
                    stat_rd_cnt <= stat_rd_cnt + 1;
                    if (stat_rd_cnt < drop_until)
                        mrsp_rdata <= init_reg[mreq_phy][1] & 16'hFFFB;
                end
            end
        end else begin
            mrsp_valid <= 1'b0;
        end
    end

    function automatic logic [15:0] model_reg(input int p, input int r);
        return wr_seen[p][r] ? wr_val[p][r] : init_reg[p][r];
    endfunction

    int nvec = 0, nfail = 0, restarts = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input bit scan);
        int guard = 0;
        restarts = 0;
        @(negedge clk);
        if (scan) scan_start = 1'b1; else check_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        check_start = 1'b0;
        while (guard < 2000) begin
            if (rxtx_restart) restarts++;
            if (done) break;
            @(negedge clk);
            guard++;
        end
        if (guard >= 2000) begin
            nvec++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected done");
        end
    endtask

    typedef struct packed {
        logic [15:0] lpa;
        logic        lock;
        logic        fd;
        logic        thr;
        logic        rst;
    } vec_t;

    // partner abilities against advertised 0x01E1 on the first PHY
    localparam vec_t VECS [8] = '{
        '{16'h01E1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{16'h00A1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{16'h0061, 1'b0, 1'b1, 1'b1, 1'b1},
        '{16'h0061, 1'b0, 1'b1, 1'b1, 1'b0},
        '{16'h0021, 1'b0, 1'b0, 1'b1, 1'b1},
        '{16'h0021, 1'b1, 1'b1, 1'b1, 1'b1},
        '{16'h0181, 1'b0, 1'b1, 1'b0, 1'b1},
        '{16'h0000, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    initial begin
        int s0;
        for (int p = 0; p < 32; p++)
            for (int r = 0; r < 8; r++) init_reg[p][r] = 16'h0;
        init_reg[3][1] = 16'h786D;
        init_reg[0][1] = 16'h8005;
        init_reg[0][4] = 16'h01E1;
        init_reg[0][0] = 16'h1000;
        init_reg[7][1] = 16'h8101;

        repeat (3) @(negedge clk);
        chk("reset busy", 32'(busy), 0);
        chk("reset count", 32'(phy_count), 0);
        chk("reset mac", {30'd0, full_duplex, tx_threshold}, 0);
        chk("reset req", 32'(mreq_valid), 0);
        rst_n = 1'b1;

        // scan in negotiation mode
        s0 = stat_rd_cnt;
        run(1'b1);
        chk("R1 status reads per address", 32'(stat_rd_cnt - s0), 32);
        chk("R2 count", 32'(phy_count), 2);
        chk("R1 entry0", 32'(phy_addrs[4:0]), 3);
        chk("R1 entry1 wraps to 0", 32'(phy_addrs[9:5]), 0);
        chk("R4 built advert", 32'(model_reg(3, 4)), 32'h01E1);
        chk("R5 ctrl enable+restart", 32'(model_reg(3, 0)), 32'h1200);
        chk("R7 no write when unchanged", 32'(wr_cnt[0]), 0);
        chk("R2 rejected address untouched", 32'(wr_cnt[7]), 0);

        // duplex/threshold table
        for (int i = 0; i < 8; i++) begin
            init_reg[3][5] = VECS[i].lpa;
            cfg_fd_lock = VECS[i].lock;
            run(1'b0);
            chk("R9 duplex", 32'(full_duplex), 32'(VECS[i].fd));
            chk("R10 threshold", 32'(tx_threshold), 32'(VECS[i].thr));
            chk("R11 restart", 32'(restarts), 32'(VECS[i].rst));
        end
        cfg_fd_lock = 1'b0;

        // single latched-low report
        init_reg[3][5] = 16'h01E1;
        s0 = stat_rd_cnt;
        drop_until = stat_rd_cnt + 1;
        run(1'b0);
        chk("R8 reread count", 32'(stat_rd_cnt - s0), 2);
        chk("R8 link after reread", 32'(link_up), 1);
        chk("R9 duplex after reread", 32'(full_duplex), 1);

        // persistent loss
        init_reg[3][5] = 16'h0021;
        s0 = stat_rd_cnt;
        drop_until = stat_rd_cnt + 2;
        run(1'b0);
        chk("R8 link lost", 32'(link_up), 0);
        chk("R8 mac unchanged", {30'd0, full_duplex, tx_threshold}, 32'h2);
        chk("R11 no restart on loss", 32'(restarts), 0);

        // forced media scan
        clr_model = 1'b1;
        @(negedge clk);
        clr_model = 1'b0;
        cfg_autoneg = 1'b0;
        cfg_force_fd = 1'b1;
        init_reg[3][0] = 16'h5D80;
        init_reg[3][4] = 16'h0061;
        run(1'b1);
        chk("R6 forced ctrl", 32'(model_reg(3, 0)), 32'h0100);
        chk("R4 advert kept", 32'(wr_seen[3][4]), 0);
        chk("R6 forced ctrl phy0", 32'(model_reg(0, 0)), 32'h0100);

        // table fills before the sweep ends
        clr_model = 1'b1;
        @(negedge clk);
        clr_model = 1'b0;
        cfg_force_100 = 1'b1;
        init_reg[3][1] = 16'h0;
        init_reg[0][1] = 16'h0;
        init_reg[1][1] = 16'h8001;
        init_reg[2][1] = 16'h0800;
        init_reg[5][1] = 16'h8001;
        init_reg[9][1] = 16'h1000;
        init_reg[20][1] = 16'h8001;
        s0 = stat_rd_cnt;
        run(1'b1);
        chk("R3 count full", 32'(phy_count), 4);
        chk("R3 last entry", 32'(phy_addrs[19:15]), 9);
        chk("R3 reads stop", 32'(stat_rd_cnt - s0), 9);
        chk("R3 later PHY untouched", 32'(wr_cnt[20]), 0);
        chk("R6 forced 100 fd", 32'(model_reg(1, 0)), 32'h2100);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule